// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Drive Sequencer

This block produces the time-multiplexed drive level codes for a passive LCD panel with five common lines and eighty segment lines. A clock-enable tick arrives at the display oscillator rate. Every tick advances a slot counter. Each common line is selected for a fixed slot of ticks. After the last active common the scan wraps to the first one and the drive polarity flips, so over two frames the panel sees no net DC voltage.

The number of scanned commons is chosen at run time from a 2-bit select, giving 1/3, 1/4 or 1/5 duty. The frame rate is therefore the tick rate multiplied by the duty and divided by the slot length. Each segment's level follows the latched display bit of the common that is currently selected. An active-low blank input turns every segment off without disturbing the latched data. The analog switch matrix that turns the level codes into bias voltages sits outside this block.

Top module: `lcd_mux_seq`

## Requirements
- R1: The duty select maps 2'b00 to three scanned commons, 2'b01 to four, and 2'b10 or 2'b11 to five.
- R2: Each common stays selected for exactly 16 ticks, so a frame lasts 16·N ticks at duty 1/N.
- R3: At any time exactly one common is selected. The scan order is com1, com2, and so on up to the last active common, then back to com1.
- R4: Level codes are 2'b11=H, 2'b10=M1, 2'b01=M2, 2'b00=L. In the positive phase the selected common drives H and all other commons drive M2. In the negative phase the selected common drives L and all other commons drive M1.
- R5: The polarity flips each time the scan wraps from the last active common back to com1.
- R6: A segment whose bit for the selected common is 1 drives L in the positive phase and H in the negative phase. Bit planes[c*80+n] holds segment n+1 for common c+1.
- R7: A segment whose bit is 0 drives M1 in the positive phase and M2 in the negative phase.
- R8: While blank_n is low, every segment drives its off level (R7) and the scan keeps running. When blank_n returns high, the segments show the latched data again.
- R9: Commons beyond the selected duty are never selected. They hold the non-select level of the current phase.
- R10: On a tick where the duty select differs from the value the block is currently using, the block adopts the new value and restarts at com1, slot 0, positive phase.
- R11: After reset, com1 is selected in the positive phase at slot 0. Without a tick, the scan state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oscillator-rate clock enable |
| duty_sel | input | 2 | Duty select (R1 encoding) |
| blank_n | input | 1 | Active-low blank of all segments |
| planes | input | 400 | Latched display bits, 80 per common, common 1 lowest |
| com_lvl | output | 10 | Two-bit level code per common, com1 in bits 1:0 |
| seg_lvl | output | 160 | Two-bit level code per segment, seg1 in bits 1:0 |

## Verification
Some properties hold on every cycle, and the assertions check these. Exactly one common is at a select level. The unselected commons sit at the mid level of the same phase. No segment leaves the pair of levels allowed by the selected common's phase. Blanking leaves no segment in an on level. The common outputs hold still between ticks. Other behaviour depends on counting ticks over time, and only the bench's scenarios can show it. This covers the 16-tick slot length, the wrap point for each duty, the polarity flip at frame end, the restart on a duty change, and the return of the data after blanking.

// File: rtl/lcdm_pkg.sv
package lcdm_pkg;

    localparam int COM_MAX    = 5;
    localparam int SEG_NUM    = 80;
    localparam int SLOT_TICKS = 16;
    localparam int COM_W      = $clog2(COM_MAX);

    typedef enum logic [1:0] {
        LV_L  = 2'b00,
        LV_M2 = 2'b01,
        LV_M1 = 2'b10,
        LV_H  = 2'b11
    } lvl_e;

    typedef struct packed {
        logic [COM_W-1:0] com;
        logic             neg;
    } scan_t;

    // number of commons scanned for a duty select code
    function automatic logic [COM_W:0] active_coms(input logic [1:0] sel);
        if (sel[1])      return (COM_W+1)'(COM_MAX);
        else if (sel[0]) return (COM_W+1)'(4);
        else             return (COM_W+1)'(3);
    endfunction

    function automatic lvl_e com_level(input logic selected, input logic neg);
        if (selected) return neg ? LV_L : LV_H;
        else          return neg ? LV_M1 : LV_M2;
    endfunction

    function automatic lvl_e seg_level(input logic on, input logic neg);
        if (on) return neg ? LV_H : LV_L;
        else    return neg ? LV_M2 : LV_M1;
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcdm_pkg::*;
#(
    parameter int SLOT = SLOT_TICKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] duty_sel,
    output scan_t      scan
);
    localparam int SW = $clog2(SLOT);

    logic [SW-1:0]  slot_q;
    logic [1:0]     duty_q;
    scan_t          scan_q;
    logic [COM_W:0] n_act;
    logic           last_com;
    logic           last_slot;

    assign n_act     = active_coms(duty_q);
    assign last_com  = ({1'b0, scan_q.com} == n_act - 1'b1);
    assign last_slot = (slot_q == SW'(SLOT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            scan_q <= '0;
            duty_q <= duty_sel;
        end else if (tick) begin
            if (duty_sel != duty_q) begin
                duty_q <= duty_sel;
                slot_q <= '0;
                scan_q <= '0;
            end else if (last_slot) begin
                slot_q <= '0;
                if (last_com) begin
                    scan_q.com <= '0;
                    scan_q.neg <= ~scan_q.neg;
                end else begin
                    scan_q.com <= scan_q.com + 1'b1;
                end
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign scan = scan_q;

endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
    import lcdm_pkg::*;
#(
    parameter int NCOM = COM_MAX
) (
    input  scan_t             scan,
    output logic [2*NCOM-1:0] com_lvl
);
    for (genvar c = 0; c < NCOM; c++) begin : g_com
        assign com_lvl[2*c +: 2] = com_level(scan.com == COM_W'(c), scan.neg);
    end
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
    import lcdm_pkg::*;
#(
    parameter int NCOM = COM_MAX,
    parameter int NSEG = SEG_NUM
) (
    input  scan_t                  scan,
    input  logic                   blank_n,
    input  logic [NCOM*NSEG-1:0]   planes,
    output logic [2*NSEG-1:0]      seg_lvl
);
    logic [NSEG-1:0] row;

    always_comb begin
        row = '0;
        for (int c = 0; c < NCOM; c++) begin
            if (scan.com == COM_W'(c)) row = planes[c*NSEG +: NSEG];
        end
    end

    for (genvar n = 0; n < NSEG; n++) begin : g_seg
        assign seg_lvl[2*n +: 2] = seg_level(row[n] & blank_n, scan.neg);
    end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcdm_pkg::*;
#(
    parameter int NCOM = COM_MAX,
    parameter int NSEG = SEG_NUM,
    parameter int SLOT = SLOT_TICKS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [1:0]           duty_sel,
    input  logic                 blank_n,
    input  logic [NCOM*NSEG-1:0] planes,
    output logic [2*NCOM-1:0]    com_lvl,
    output logic [2*NSEG-1:0]    seg_lvl
);
    scan_t scan;

    lcd_scan_timer #(.SLOT(SLOT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .duty_sel (duty_sel),
        .scan     (scan)
    );

    lcd_com_drive #(.NCOM(NCOM)) u_com (
        .scan    (scan),
        .com_lvl (com_lvl)
    );

    lcd_seg_drive #(.NCOM(NCOM), .NSEG(NSEG)) u_seg (
        .scan    (scan),
        .blank_n (blank_n),
        .planes  (planes),
        .seg_lvl (seg_lvl)
    );
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
    parameter int NCOM = 5,
    parameter int NSEG = 80
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              blank_n,
    input logic [2*NCOM-1:0] com_lvl,
    input logic [2*NSEG-1:0] seg_lvl
);
    logic [7:0] nsel;
    logic sel_h, sel_l, com_has_m1, com_has_m2;
    logic seg_hi_side, seg_lo_side, seg_on_any;

    always_comb begin
        nsel = '0; sel_h = 1'b0; sel_l = 1'b0;
        com_has_m1 = 1'b0; com_has_m2 = 1'b0;
        for (int c = 0; c < NCOM; c++) begin
            case (com_lvl[2*c +: 2])
                2'b11:   begin nsel = nsel + 1'b1; sel_h = 1'b1; end
                2'b00:   begin nsel = nsel + 1'b1; sel_l = 1'b1; end
                2'b10:   com_has_m1 = 1'b1;
                default: com_has_m2 = 1'b1;
            endcase
        end
    end

    always_comb begin
        seg_hi_side = 1'b0; seg_lo_side = 1'b0; seg_on_any = 1'b0;
        for (int n = 0; n < NSEG; n++) begin
            case (seg_lvl[2*n +: 2])
                2'b11:   begin seg_hi_side = 1'b1; seg_on_any = 1'b1; end
                2'b01:   seg_hi_side = 1'b1;
                2'b00:   begin seg_lo_side = 1'b1; seg_on_any = 1'b1; end
                default: seg_lo_side = 1'b1;
            endcase
        end
    end

    // R3
    one_sel_chk: assert property (@(posedge clk) disable iff (rst) nsel == 8'd1);

    // R4
    com_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_h && !com_has_m1) || (sel_l && !com_has_m2));

    // R6
    seg_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_h && !seg_hi_side) || (sel_l && !seg_lo_side));

    // R8
    blank_off_chk: assert property (@(posedge clk) disable iff (rst)
        !blank_n |-> !seg_on_any);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(com_lvl));
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.NCOM(NCOM), .NSEG(NSEG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .blank_n (blank_n),
    .com_lvl (com_lvl),
    .seg_lvl (seg_lvl)
);

// File: tb/sim_lcd_mux_seq.sv
`timescale 1ns/1ps
module sim_lcd_mux_seq;
    localparam int NCOM = 5;
    localparam int NSEG = 80;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 tick = 1'b0;
    logic [1:0]           duty_sel = 2'b10;
    logic                 blank_n = 1'b1;
    logic [NCOM*NSEG-1:0] planes;
    logic [2*NCOM-1:0]    com_lvl;
    logic [2*NSEG-1:0]    seg_lvl;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lcd_mux_seq u0 (
        .clk(clk), .rst(rst), .tick(tick), .duty_sel(duty_sel),
        .blank_n(blank_n), .planes(planes), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    typedef struct packed {
        logic [1:0] duty;
        logic [7:0] nt;
        logic [2:0] idx;
        logic       neg;
    } vec_t;

    // duty, ticks applied, expected selected common (0-based), expected phase
    localparam vec_t VECS [14] = '{
        '{2'b10, 8'd0,  3'd0, 1'b0},  // R11 reset state
        '{2'b10, 8'd15, 3'd0, 1'b0},  // R2 still slot 0
        '{2'b10, 8'd1,  3'd1, 1'b0},  // R2 16th tick moves on
        '{2'b10, 8'd48, 3'd4, 1'b0},  // R3 com5 reached
        '{2'b10, 8'd16, 3'd0, 1'b1},  // R5 wrap flips phase
        '{2'b01, 8'd1,  3'd0, 1'b0},  // R10 restart
        '{2'b01, 8'd63, 3'd3, 1'b0},  // R1 four commons
        '{2'b01, 8'd1,  3'd0, 1'b1},  // R9 com5 skipped
        '{2'b00, 8'd1,  3'd0, 1'b0},  // R10 restart
        '{2'b00, 8'd47, 3'd2, 1'b0},  // R1 three commons
        '{2'b00, 8'd1,  3'd0, 1'b1},  // R9 com4 skipped
        '{2'b11, 8'd1,  3'd0, 1'b0},  // R10 restart
        '{2'b11, 8'd80, 3'd0, 1'b1},  // R1 code 11 gives five
        '{2'b10, 8'd1,  3'd0, 1'b0}   // R10 restart 11 -> 10
    };

    function automatic logic [2*NCOM-1:0] exp_com(int idx, bit neg);
        logic [2*NCOM-1:0] v;
        for (int c = 0; c < NCOM; c++)
            v[2*c +: 2] = (c == idx) ? (neg ? 2'b00 : 2'b11) : (neg ? 2'b10 : 2'b01);
        return v;
    endfunction

    function automatic logic [2*NSEG-1:0] exp_seg(int idx, bit neg, bit bl_n);
        logic [2*NSEG-1:0] v;
        for (int n = 0; n < NSEG; n++) begin
            if (planes[idx*NSEG + n] && bl_n) v[2*n +: 2] = neg ? 2'b11 : 2'b00;
            else                              v[2*n +: 2] = neg ? 2'b01 : 2'b10;
        end
        return v;
    endfunction

    task automatic check_state(int idx, bit neg, bit bl_n, string tag);
        logic [2*NCOM-1:0] ec;
        logic [2*NSEG-1:0] es;
        ec = exp_com(idx, neg);
        es = exp_seg(idx, neg, bl_n);
        checks++;
        if (com_lvl !== ec) begin
            failures++;
            $display("FAIL %s commons: got %h expected %h", tag, com_lvl, ec);
        end
        checks++;
        if (seg_lvl !== es) begin
            failures++;
            $display("FAIL %s segments: got %h expected %h", tag, seg_lvl, es);
        end
    endtask

    task automatic do_ticks(int n);
        if (n > 0) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                tick = 1'b1;
            end
            @(negedge clk);
            tick = 1'b0;
        end
        #1;
    endtask

    initial begin
        for (int c = 0; c < NCOM; c++)
            for (int n = 0; n < NSEG; n++)
                planes[c*NSEG + n] = ((n * 7 + c * 3) % 5) < 2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // table walk: R1 R2 R3 R4 R5 R6 R7 R9 R10 R11
        for (int r = 0; r < 14; r++) begin
            @(negedge clk);
            duty_sel = VECS[r].duty;
            do_ticks(int'(VECS[r].nt));
            check_state(int'(VECS[r].idx), VECS[r].neg, 1'b1, $sformatf("row %0d R1/R2/R3/R4/R5/R6/R7/R9/R10", r));
        end

        // R11 no tick, no change
        repeat (10) @(negedge clk);
        #1;
        check_state(0, 1'b0, 1'b1, "R11 hold");

        // R8 blank in positive phase while scan runs
        blank_n = 1'b0;
        #1;
        check_state(0, 1'b0, 1'b0, "R8 blank pos");
        do_ticks(16);
        check_state(1, 1'b0, 1'b0, "R8 blank scan runs");
        blank_n = 1'b1;
        #1;
        check_state(1, 1'b0, 1'b1, "R8 restore");

        // R8 blank in negative phase
        do_ticks(64);
        blank_n = 1'b0;
        #1;
        check_state(0, 1'b1, 1'b0, "R8 blank neg");
        blank_n = 1'b1;
        #1;
        check_state(0, 1'b1, 1'b1, "R8 restore neg");

        // R11 reset mid-slot then full slot count again
        do_ticks(20);
        check_state(1, 1'b1, 1'b1, "R2 mid slot");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check_state(0, 1'b0, 1'b1, "R11 reset");
        do_ticks(15);
        check_state(0, 1'b0, 1'b1, "R11 slot cleared");
        do_ticks(1);
        check_state(1, 1'b0, 1'b1, "R2 after reset");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule